// File: doc/BRIEF.md
# SPI Controller with Slave-Select Management

This block is a full-duplex serial peripheral controller that moves 8-bit frames through one shift register, most significant bit first. It runs as master or as slave. As master it produces the serial clock from the system clock through a power-of-two divider. It sends the outgoing byte on the master-out line and, in the same frame, collects the byte that comes back on the master-in line. As slave it shifts only on the clock an external master supplies, and only while it is selected.

A select stage forms an internal select level. That level comes from a software control bit when software select is enabled, or from the synchronized select pin when it is not. An enabled master with select output turned on drives the select pin low to address the slaves on the bus. An enabled master with select output turned off treats the pin as an input: a low internal select means a second master has taken the bus. This raises a sticky fault, and the block withdraws from the bus until the fault is cleared.

Software writes a byte through a one-entry transmit buffer and reads the last received byte through a receive buffer. The flags `txe`, `rxne`, `busy` and `mode_fault` report progress. Each pin is split into a value, an output enable and an input.

Top module: `spi_ctrl`

## Requirements
- R1: As master, the frame puts bit 7 of the written byte on `mosi_o` first and changes `mosi_o` only after a falling SCK edge. It samples `miso_i` on each rising edge, and the received byte appears on `rd_data` with the first sampled bit in bit 7.
- R2: `sck_o` is low whenever no frame is in progress. In a master frame each SCK half-period lasts 2^`cfg_div` clock cycles (`cfg_div` 0..7, a division of 2 to 256), and the frame holds exactly 8 rising edges.
- R3: A write is taken only while `txe` is 1. `txe` reads 0 in the cycle after the write and 1 again once the byte has moved into the shift register. A write made while `txe` is 0 is discarded and starts no frame.
- R4: `rxne` becomes 1 in the cycle in which `busy` falls at the end of a completed frame. It reads 0 in the cycle after a `rd_en` pulse.
- R5: With `cfg_ssm` = 1, the internal select equals `cfg_ssi` one cycle later in effect, and `nss_i` has no influence.
- R6: With `cfg_ssm` = 0, the internal select follows `nss_i` through a two-stage synchronizer. In slave mode `miso_oe` therefore responds to a change of `nss_i` two clock edges later.
- R7: `nss_oe` is 1 and `nss_o` is 0 when the block is enabled, acting as master and has `cfg_ssoe` = 1. In every other case `nss_oe` is 0.
- R8: An enabled master with `cfg_ssoe` = 0 whose internal select is low sets `mode_fault` at the next clock edge. This happens 3 edges after `nss_i` falls when `cfg_ssm` = 0. While the fault is set, `master_act`, `sck_oe` and `mosi_oe` are 0 and any frame is dropped.
- R9: `mode_fault` stays set until `fault_clr` is pulsed. With the select then high, it reads 0 in the next cycle.
- R10: An enabled slave (`cfg_master` = 0) whose internal select is low drives `miso_oe` = 1. It presents bit 7 of its loaded byte first, samples the synchronized `mosi_i` on each SCK rise and shifts on each fall. With the internal select high it ignores SCK and receives nothing.
- R11: If a slave's internal select rises during a frame, the frame is dropped: `busy` falls, `rxne` stays 0, and the next frame starts again at bit 0.
- R12: In master mode `busy` is 1 from the second cycle after the write for exactly 16·2^`cfg_div` cycles. In slave mode it is 1 from the first synchronized SCK rise until the eighth fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Controller enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_ssm | input | 1 | 1 = internal select taken from `cfg_ssi` |
| cfg_ssi | input | 1 | Software select level |
| cfg_ssoe | input | 1 | Master drives the select pin low |
| cfg_div | input | 3 | SCK half-period exponent (2^n cycles) |
| fault_clr | input | 1 | Clears `mode_fault` |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears `rxne` |
| rd_data | output | 8 | Last received byte |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output enable of the clock pin |
| mosi_i | input | 1 | Master-out line seen as slave |
| mosi_o | output | 1 | Master-out line driven as master |
| mosi_oe | output | 1 | Output enable of the master-out pin |
| miso_i | input | 1 | Master-in line seen as master |
| miso_o | output | 1 | Master-in line driven as slave |
| miso_oe | output | 1 | Output enable of the master-in pin |
| nss_i | input | 1 | Select pin input |
| nss_o | output | 1 | Select pin value (always low) |
| nss_oe | output | 1 | Output enable of the select pin |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer holds an unread byte |
| busy | output | 1 | Frame in progress |
| mode_fault | output | 1 | Sticky multimaster fault |
| master_act | output | 1 | Effective master role (cleared by a fault) |

## Verification
A write shows on `txe` one cycle later, and the master frame starts at the second edge after the write. `busy` then lasts 16·2^`cfg_div` cycles, and `rxne` with the received byte appears in the cycle after the last fall. The bench counts these cycles one by one and samples every output on the falling clock edge, so each value is read exactly one register stage after the edge that produced it. Pin-driven effects pass through the two synchronizer stages: `miso_oe` is checked at the second edge after `nss_i` moves and `mode_fault` at the third, and slave stimulus leaves several cycles of margin around every SCK edge. The master sweep covers every divider setting from 0 to 3 plus the widest one with several byte pairs, and checks the spacing between SCK rises against 2·2^`cfg_div`.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
module spi_pin_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t sq, sd;

    always_comb begin
        sd = sq;
        sd.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sd.stg[i] = sq.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                sq.stg[i] <= RST_VAL;
            end
        end else begin
            sq <= sd;
        end
    end

    assign dout = sq.stg[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
// Half-period tick generator: one tick every 2^div cycles while run is high.
module spi_sck_gen #(
    parameter int DIV_W = 3,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gen_t;

    gen_t gq, gd;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = ~({CNT_W{1'b1}} << div);
        tick = run && (gq.cnt == lim);
        gd   = gq;
        if (!run || tick) begin
            gd.cnt = '0;
        end else begin
            gd.cnt = gq.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gq <= '0;
        else        gq <= gd;
    end
endmodule

// File: rtl/spi_nss_ctl.sv
// Internal select selection, select-pin drive and multimaster fault.
module spi_nss_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic cfg_master,
    input  logic cfg_ssm,
    input  logic cfg_ssi,
    input  logic cfg_ssoe,
    input  logic nss_s,
    input  logic fault_clr,
    output logic nss_int,
    output logic master_eff,
    output logic en_eff,
    output logic fault,
    output logic nss_o,
    output logic nss_oe
);
    typedef struct packed {
        logic fault;
    } sel_t;

    sel_t nq, nd;
    logic conflict;

    always_comb begin
        nss_int  = cfg_ssm ? cfg_ssi : nss_s;
        conflict = cfg_en && cfg_master && !cfg_ssoe && !nss_int;
        nd       = nq;
        if (nq.fault && fault_clr) nd.fault = 1'b0;
        if (conflict && !nq.fault) nd.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nq <= '0;
        else        nq <= nd;
    end

    assign fault      = nq.fault;
    assign master_eff = cfg_master && !nq.fault;
    assign en_eff     = cfg_en && !nq.fault;
    assign nss_oe     = master_eff && en_eff && cfg_ssoe;
    assign nss_o      = 1'b0;
endmodule

// File: rtl/spi_shift_core.sv
// Shift register, bit counter and byte buffers for both roles.
module spi_shift_core
    import spi_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              en,
    input  logic              nss_int,
    input  logic              tick,
    input  logic              miso_i,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck_o,
    output logic              sdo,
    output logic              txe,
    output logic              rxne,
    output logic              busy
);
    typedef struct packed {
        xfer_state_e       st;
        logic [BIT_W-1:0]  bitn;
        logic              sck;
        logic              rxbit;
        logic              sck_prev;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] rxbuf;
        logic              txfull;
        logic              rxne;
    } core_t;

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    core_t cq, cd;
    logic active, s_rise, s_fall, step_rise, step_fall, last;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        cd          = cq;
        cd.sck_prev = sck_s;
        s_rise      = sck_s && !cq.sck_prev;
        s_fall      = !sck_s && cq.sck_prev;
        active      = en && (master || !nss_int);
        last        = (cq.bitn == LAST_BIT);
        shifted     = {cq.shreg[DATA_W-2:0], cq.rxbit};
        step_rise   = master ? (tick && !cq.sck) : s_rise;
        step_fall   = master ? (tick && cq.sck) : s_fall;

        if (wr_en && !cq.txfull) begin
            cd.txbuf  = wr_data;
            cd.txfull = 1'b1;
        end
        if (rd_en) cd.rxne = 1'b0;

        if (!active) begin
            if (cq.st == ST_RUN) cd.shreg = '0;
            cd.st   = ST_IDLE;
            cd.bitn = '0;
            cd.sck  = 1'b0;
            if (en && !master && cq.txfull) begin
                cd.shreg  = cq.txbuf;
                cd.txfull = 1'b0;
            end
        end else if (cq.st == ST_IDLE) begin
            if (cq.txfull) begin
                cd.shreg  = cq.txbuf;
                cd.txfull = 1'b0;
                if (master) begin
                    cd.st   = ST_RUN;
                    cd.bitn = '0;
                    cd.sck  = 1'b0;
                end
            end else if (!master && s_rise) begin
                cd.st    = ST_RUN;
                cd.rxbit = mosi_s;
            end
        end else begin
            if (master && tick) cd.sck = !cq.sck;
            if (step_rise) cd.rxbit = master ? miso_i : mosi_s;
            if (step_fall) begin
                if (last) begin
                    cd.rxbuf = shifted;
                    cd.rxne  = 1'b1;
                    cd.st    = ST_IDLE;
                    cd.bitn  = '0;
                    cd.shreg = '0;
                end else begin
                    cd.shreg = shifted;
                    cd.bitn  = cq.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    assign rx_data = cq.rxbuf;
    assign sck_o   = cq.sck;
    assign sdo     = cq.shreg[DATA_W-1];
    assign txe     = !cq.txfull;
    assign rxne    = cq.rxne;
    assign busy    = (cq.st == ST_RUN);
endmodule

// File: rtl/spi_ctrl.sv
// Top level: pin synchronizers, select logic, clock divider, shift core.
module spi_ctrl #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic              cfg_ssm,
    input  logic              cfg_ssi,
    input  logic              cfg_ssoe,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              fault_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              nss_i,
    output logic              nss_o,
    output logic              nss_oe,
    output logic              txe,
    output logic              rxne,
    output logic              busy,
    output logic              mode_fault,
    output logic              master_act
);
    localparam int CNT_W = (1 << DIV_W) - 1;
    localparam int BIT_W = $clog2(DATA_W);

    logic [2:0] pins_s;
    logic sck_s, mosi_s, nss_s;
    logic nss_int, master_eff, en_eff, tick, sdo;

    spi_pin_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({nss_i, mosi_i, sck_i}),
        .dout (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign nss_s  = pins_s[2];

    spi_nss_ctl u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_master(cfg_master),
        .cfg_ssm   (cfg_ssm),
        .cfg_ssi   (cfg_ssi),
        .cfg_ssoe  (cfg_ssoe),
        .nss_s     (nss_s),
        .fault_clr (fault_clr),
        .nss_int   (nss_int),
        .master_eff(master_eff),
        .en_eff    (en_eff),
        .fault     (mode_fault),
        .nss_o     (nss_o),
        .nss_oe    (nss_oe)
    );

    spi_sck_gen #(
        .DIV_W(DIV_W),
        .CNT_W(CNT_W)
    ) u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy && master_eff),
        .div  (cfg_div),
        .tick (tick)
    );

    spi_shift_core #(
        .DATA_W(DATA_W),
        .BIT_W (BIT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (master_eff),
        .en     (en_eff),
        .nss_int(nss_int),
        .tick   (tick),
        .miso_i (miso_i),
        .sck_s  (sck_s),
        .mosi_s (mosi_s),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rx_data(rd_data),
        .sck_o  (sck_o),
        .sdo    (sdo),
        .txe    (txe),
        .rxne   (rxne),
        .busy   (busy)
    );

    assign sck_oe     = master_eff && en_eff;
    assign mosi_oe    = master_eff && en_eff;
    assign mosi_o     = sdo;
    assign miso_o     = sdo;
    assign miso_oe    = !master_eff && en_eff && !nss_int;
    assign master_act = master_eff;
endmodule

// File: rtl/spi_ctrl_chk.sv
// Property checker bound to the top module.
module spi_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_ssoe,
    input logic fault_clr,
    input logic wr_en,
    input logic rd_en,
    input logic sck_o,
    input logic sck_oe,
    input logic mosi_oe,
    input logic nss_o,
    input logic nss_oe,
    input logic txe,
    input logic rxne,
    input logic busy,
    input logic mode_fault,
    input logic master_act
);
    a_r7_select_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (master_act && cfg_en && cfg_ssoe) |-> (nss_oe && !nss_o));

    a_r7_select_release: assert property (@(posedge clk) disable iff (!rst_n)
        nss_oe |-> (master_act && cfg_ssoe));

    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> (!sck_oe && !mosi_oe && !master_act));

    a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !fault_clr) |=> mode_fault);

    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o);

    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && txe) |=> !txe);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> !rxne);
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_ssoe  (cfg_ssoe),
    .fault_clr (fault_clr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .nss_o     (nss_o),
    .nss_oe    (nss_oe),
    .txe       (txe),
    .rxne      (rxne),
    .busy      (busy),
    .mode_fault(mode_fault),
    .master_act(master_act)
);

// File: tb/spi_ctrl_tb.sv
`timescale 1ns/1ps
module spi_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_master = 1'b0, cfg_ssm = 1'b1, cfg_ssi = 1'b1, cfg_ssoe = 1'b0;
    logic [2:0] cfg_div = '0;
    logic fault_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, nss_i = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, nss_o, nss_oe;
    logic txe, rxne, busy, mode_fault, master_act;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_ssm(cfg_ssm), .cfg_ssi(cfg_ssi), .cfg_ssoe(cfg_ssoe), .cfg_div(cfg_div),
        .fault_clr(fault_clr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .nss_i(nss_i), .nss_o(nss_o),
        .nss_oe(nss_oe), .txe(txe), .rxne(rxne), .busy(busy),
        .mode_fault(mode_fault), .master_act(master_act)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_rx();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Master frame with a bench-side slave answering on miso_i.
    task automatic master_xfer(input int dv, input logic [7:0] tx_b, input logic [7:0] sl_b);
        logic [7:0] sl_sh;
        logic [7:0] seen;
        logic prv;
        int half, bc, rises, last_rise, cyc, bad_gap;
        half = 1 << dv;
        cfg_div = 3'(dv);
        sl_sh = sl_b;
        miso_i = sl_b[7];
        seen = '0; prv = 1'b0; bc = 0; rises = 0; last_rise = 0; cyc = 0; bad_gap = 0;
        wr_en = 1'b1; wr_data = tx_b;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 txe after write", int'(txe), 0);
        chk("R12 busy before load", int'(busy), 0);
        @(negedge clk);
        chk("R3 txe after load", int'(txe), 1);
        while (busy && cyc < 10000) begin
            bc++;
            if (sck_o && !prv) begin
                seen = {seen[6:0], mosi_o};
                if (rises > 0 && (cyc - last_rise) != 2 * half) bad_gap++;
                last_rise = cyc;
                rises++;
            end
            if (!sck_o && prv) begin
                sl_sh = sl_sh << 1;
                miso_i = sl_sh[7];
            end
            prv = sck_o;
            cyc++;
            @(negedge clk);
        end
        chk("R12 busy length", bc, 16 * half);
        chk("R2 rising edges", rises, 8);
        chk("R2 sck period", bad_gap, 0);
        chk("R2 sck idle low", int'(sck_o), 0);
        chk("R1 mosi byte", int'(seen), int'(tx_b));
        chk("R4 rxne set", int'(rxne), 1);
        chk("R1 received byte", int'(rd_data), int'(sl_b));
        read_rx();
        chk("R4 rxne cleared", int'(rxne), 0);
    endtask

    // Bench acts as external master for the slave role.
    task automatic slave_bits(input logic [7:0] mb, input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mb[7 - i];
            tick_n(4);
            sck_i = 1'b1;
            tick_n(3);
            got = {got[6:0], miso_o};
            tick_n(3);
            sck_i = 1'b0;
        end
        tick_n(6);
    endtask

    task automatic slave_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        tick_n(3);
    endtask

    initial begin
        logic [7:0] got;
        tick_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset txe", int'(txe), 1);
        chk("R4 reset rxne", int'(rxne), 0);
        chk("R12 reset busy", int'(busy), 0);
        chk("R9 reset fault", int'(mode_fault), 0);
        chk("R7 reset nss_oe", int'(nss_oe), 0);

        // Master sweep, select output on, software select high.
        cfg_en = 1'b1; cfg_master = 1'b1; cfg_ssm = 1'b1; cfg_ssi = 1'b1; cfg_ssoe = 1'b1;
        @(negedge clk);
        chk("R7 nss driven", int'(nss_oe), 1);
        chk("R7 nss low", int'(nss_o), 0);
        for (int dv = 0; dv < 4; dv++) begin
            master_xfer(dv, 8'hA5 ^ 8'(dv * 37), 8'h3C + 8'(dv * 11));
            master_xfer(dv, 8'h80, 8'h01);
            master_xfer(dv, 8'h7F, 8'hFE);
        end
        master_xfer(7, 8'h96, 8'h69);

        // R3: second write while buffer full is dropped.
        cfg_div = 3'd0;
        wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_data = 8'h22;
        chk("R3 txe low on second write", int'(txe), 0);
        @(negedge clk);
        wr_en = 1'b0;
        tick_n(40);
        read_rx();
        tick_n(40);
        chk("R3 dropped write no frame", int'(busy), 0);
        chk("R3 dropped write no rxne", int'(rxne), 0);
        chk("R3 txe idle", int'(txe), 1);

        // Select output off: pin becomes an input.
        cfg_ssoe = 1'b0; cfg_ssm = 1'b0; nss_i = 1'b1;
        tick_n(4);
        chk("R7 nss released", int'(nss_oe), 0);
        chk("R8 no fault with select high", int'(mode_fault), 0);
        nss_i = 1'b0;
        @(negedge clk);
        chk("R8 fault edge1", int'(mode_fault), 0);
        @(negedge clk);
        chk("R8 fault edge2", int'(mode_fault), 0);
        @(negedge clk);
        chk("R8 fault edge3", int'(mode_fault), 1);
        chk("R8 master dropped", int'(master_act), 0);
        chk("R8 sck_oe off", int'(sck_oe), 0);
        chk("R8 mosi_oe off", int'(mosi_oe), 0);
        nss_i = 1'b1;
        tick_n(6);
        chk("R9 fault held", int'(mode_fault), 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R9 fault cleared", int'(mode_fault), 0);
        chk("R9 master restored", int'(master_act), 1);
        // R5: software select low gives a fault one edge later, pin high.
        cfg_ssm = 1'b1; cfg_ssi = 1'b0;
        @(negedge clk);
        chk("R5 software select fault", int'(mode_fault), 1);
        cfg_ssi = 1'b1;
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R9 fault cleared again", int'(mode_fault), 0);

        // Slave role, hardware select.
        cfg_master = 1'b0; cfg_ssm = 1'b0; nss_i = 1'b1;
        tick_n(4);
        chk("R10 miso off when unselected", int'(miso_oe), 0);
        nss_i = 1'b0;
        @(negedge clk);
        chk("R6 miso_oe edge1", int'(miso_oe), 0);
        @(negedge clk);
        chk("R6 miso_oe edge2", int'(miso_oe), 1);
        for (int k = 0; k < 4; k++) begin
            slave_write(8'hC3 ^ 8'(k * 29));
            slave_bits(8'h5A + 8'(k * 17), 8, got);
            chk("R10 slave rxne", int'(rxne), 1);
            chk("R10 slave received", int'(rd_data), int'(8'h5A + 8'(k * 17)));
            chk("R10 slave sent", int'(got), int'(8'hC3 ^ 8'(k * 29)));
            read_rx();
        end

        // R11: abort mid-frame, then a clean frame.
        slave_write(8'hF0);
        slave_bits(8'hFF, 3, got);
        chk("R12 slave busy mid-frame", int'(busy), 1);
        nss_i = 1'b1;
        tick_n(4);
        chk("R11 abort busy", int'(busy), 0);
        chk("R11 abort rxne", int'(rxne), 0);
        nss_i = 1'b0;
        tick_n(4);
        slave_bits(8'h4D, 8, got);
        chk("R11 frame after abort", int'(rd_data), 32'h4D);
        read_rx();

        // R10: unselected slave ignores SCK.
        nss_i = 1'b1;
        tick_n(4);
        slave_bits(8'hAA, 8, got);
        chk("R10 ignored rxne", int'(rxne), 0);
        chk("R10 ignored busy", int'(busy), 0);

        // R5: software select low, pin high, transfer runs.
        cfg_ssm = 1'b1; cfg_ssi = 1'b0;
        slave_write(8'h9E);
        slave_bits(8'h27, 8, got);
        chk("R5 ssi selects", int'(rd_data), 32'h27);
        chk("R5 ssi sent", int'(got), 32'h9E);
        read_rx();
        // R5: software select high, pin low, nothing received.
        cfg_ssi = 1'b1; nss_i = 1'b0;
        tick_n(4);
        slave_bits(8'h33, 8, got);
        chk("R5 pin ignored rxne", int'(rxne), 0);
        chk("R5 pin ignored miso_oe", int'(miso_oe), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule